// File: doc/BRIEF.md
# Reference Frequency Monitor with Holdover

This block watches one of two external reference clocks and decides whether its frequency matches a chosen rational multiple of a local oscillator clock. It counts reference edges during fixed gate windows timed by the oscillator. It compares each count with an expected count taken from a 4-bit ratio code. It raises a reference-good flag when the reference sits inside a narrow window around that count.

The block also owns a digital tuning word for the oscillator. While the reference is judged good, every completed window nudges the word toward the reference by a shifted copy of the count error. When the reference drifts away or stops, the flag drops and the word keeps its last value. The oscillator then runs on without a reference. When the reference comes back, the flag returns and tracking resumes with no outside action. One code value switches the whole block into a bypass state.

All logic except a small prescaler per reference runs on the oscillator clock. Every control and status pin is a plain level. There is no streaming interface.

Top module: `ref_holdover_monitor`

## Requirements
- R1: While `rst_n` is low and before the first window completes, `ref_ok` is 0, `tune_code` is mid-scale (only its top bit set) and `bypass_on` is 0.
- R2: With `ref_pick` = 1 the block measures `ref_a`; with `ref_pick` = 0 it measures `ref_b`. The clock that is not selected has no effect on the result.
- R3: The reference-to-oscillator ratio for each `ratio_code` is: 1001→1, 1000→2, 1111→4, 1100→8, 1110→6, 1011→3, 1101→2, 1010→3/2, 0111→3/4, 0101→4/5, 0110→1/2, 0100→1/2, 0011→1/3, 0010→1/6, 0001→1/8. The expected count per window is floor(2^(WIN_LOG2−PRE_LOG2) × num / den), where 2^PRE_LOG2 is the prescaler division applied to the reference.
- R4: A window is in range when |measured − expected| ≤ tol, where tol = max(1, ceil(expected × TOL_PPM / 10^6)).
- R5: `ref_ok` rises only after two consecutive in-range windows and falls only after two consecutive out-of-range windows. A single window that disagrees with the current flag leaves the flag unchanged.
- R6: `tune_code` changes only one cycle after a window that was in range while `ref_ok` was 1. Otherwise it holds its value, including through a failed or stopped reference.
- R7: On each such update, `tune_code` becomes `tune_code` + (error >>> STEP_SHIFT), where error = measured − expected. The result saturates at 0 and at all-ones and never wraps.
- R8: `ratio_code` 0000 is bypass. `bypass_on` goes to 1 one clock after the code is seen, `ref_ok` is forced to 0 from the clock after that, and `tune_code` is frozen.
- R9: A change of `ratio_code` or `ref_pick` restarts the gate window and clears any partial agreement. The current flag is kept.
- R10: After a failure, a reference that returns to range sets `ref_ok` again, and tracking resumes without any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock; all judging logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | First reference clock |
| ref_b | input | 1 | Second reference clock |
| ref_pick | input | 1 | 1 selects `ref_a`, 0 selects `ref_b` |
| ratio_code | input | 4 | Ratio select; 0000 is bypass |
| ref_ok | output | 1 | Selected reference judged within range |
| tune_code | output | TUNE_W | Oscillator tuning word, tracking or held |
| bypass_on | output | 1 | Bypass state indicator |

## Verification
The bench kills the reference for half of one aligned window. A design without two-window agreement would drop `ref_ok` there, and one whose window did not restart on a code change would spread the gap over two windows. A reference held 3 % slow or fast drives the word into both rails; a wrapping adder would show a jump of the full range in one step. Bypass and reference loss are held for several windows, so a tuner that kept updating without a valid flag shows up on the first window edge. A wrong table entry shows up when the flag drops under a correctly scaled reference.

// File: rtl/ref_holdover_pkg.sv
package ref_holdover_pkg;

  typedef struct packed {
    logic [3:0] num;
    logic [3:0] den;
  } ratio_t;

  localparam logic [3:0] BYPASS_CODE = 4'b0000;

  // Reference-to-oscillator frequency ratio per select code
  function automatic ratio_t ratio_of(input logic [3:0] code);
    ratio_t r;
    case (code)
      4'b1001: r = '{num: 4'd1, den: 4'd1};
      4'b1000: r = '{num: 4'd2, den: 4'd1};
      4'b1101: r = '{num: 4'd2, den: 4'd1};
      4'b1011: r = '{num: 4'd3, den: 4'd1};
      4'b1111: r = '{num: 4'd4, den: 4'd1};
      4'b1110: r = '{num: 4'd6, den: 4'd1};
      4'b1100: r = '{num: 4'd8, den: 4'd1};
      4'b1010: r = '{num: 4'd3, den: 4'd2};
      4'b0111: r = '{num: 4'd3, den: 4'd4};
      4'b0101: r = '{num: 4'd4, den: 4'd5};
      4'b0110: r = '{num: 4'd1, den: 4'd2};
      4'b0100: r = '{num: 4'd1, den: 4'd2};
      4'b0011: r = '{num: 4'd1, den: 4'd3};
      4'b0010: r = '{num: 4'd1, den: 4'd6};
      4'b0001: r = '{num: 4'd1, den: 4'd8};
      default: r = '{num: 4'd0, den: 4'd1};
    endcase
    return r;
  endfunction

  function automatic longint unsigned expected_count(input logic [3:0] code,
                                                     input int unsigned shift);
    ratio_t r;
    longint unsigned base;
    r    = ratio_of(code);
    base = longint'(1) << shift;
    return (base * longint'(r.num)) / longint'(r.den);
  endfunction

  function automatic longint unsigned tol_count(input longint unsigned e,
                                                input int unsigned ppm);
    longint unsigned t;
    t = (e * longint'(ppm) + 64'd999999) / 64'd1000000;
    return (t < 1) ? 64'd1 : t;
  endfunction

endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
  parameter int unsigned PRE_LOG2 = 5
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic tap
);

  logic [PRE_LOG2-1:0] cnt;

  // Divides the reference by 2^PRE_LOG2 so that fast references can cross
  // into the oscillator domain through a plain synchronizer.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tap <= 1'b0;
    else        tap <= cnt[PRE_LOG2-1];
  end

endmodule

// File: rtl/edge_window.sv
module edge_window #(
  parameter int unsigned WIN_LOG2 = 16,
  parameter int unsigned CNT_W    = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_async,
  input  logic             restart,
  input  logic             enable,
  output logic             win_done,
  output logic [CNT_W-1:0] win_count
);

  localparam logic [CNT_W-1:0] MAX_EDGES = CNT_W'((64'd1 << (WIN_LOG2 - 1)) + 64'd1);

  logic s1, s2, s3;
  logic rise;
  logic [WIN_LOG2-1:0] win_cnt;
  logic [CNT_W-1:0]    edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tap_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      edge_cnt  <= '0;
      win_done  <= 1'b0;
      win_count <= '0;
    end else if (restart || !enable) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      win_done <= 1'b0;
    end else if (&win_cnt) begin
      win_count <= edge_cnt + CNT_W'(rise);
      edge_cnt  <= '0;
      win_cnt   <= '0;
      win_done  <= 1'b1;
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      edge_cnt <= edge_cnt + CNT_W'(rise);
      win_done <= 1'b0;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (win_count <= MAX_EDGES)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done); // R9

endmodule

// File: rtl/window_judge.sv
module window_judge #(
  parameter int unsigned CNT_W = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    enable,
  input  logic                    win_done,
  input  logic [CNT_W-1:0]        win_count,
  input  logic [CNT_W-1:0]        exp_cnt,
  input  logic [CNT_W-1:0]        tol,
  output logic                    flag,
  output logic                    upd,
  output logic signed [CNT_W:0]   err_q
);

  logic signed [CNT_W:0] diff;
  logic [CNT_W:0]        mag;
  logic                  in_rng;
  logic                  streak;

  assign diff   = $signed({1'b0, win_count}) - $signed({1'b0, exp_cnt});
  assign mag    = diff[CNT_W] ? (CNT_W+1)'(-diff) : diff;
  assign in_rng = (mag <= {1'b0, tol});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      streak <= 1'b0;
    end else if (!enable) begin
      flag   <= 1'b0;
      streak <= 1'b0;
    end else if (restart) begin
      streak <= 1'b0;
    end else if (win_done) begin
      if (in_rng == flag) begin
        streak <= 1'b0;
      end else if (streak) begin
        flag   <= in_rng;
        streak <= 1'b0;
      end else begin
        streak <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd   <= 1'b0;
      err_q <= '0;
    end else begin
      upd   <= win_done & in_rng & flag & enable & ~restart;
      err_q <= diff;
    end
  end

  AST_FLAG_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag) |-> ($past(win_done) || !$past(enable))); // R5
  AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !flag); // R8
  AST_UPD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> flag); // R6

endmodule

// File: rtl/tune_tracker.sv
module tune_tracker #(
  parameter int unsigned TUNE_W     = 16,
  parameter int unsigned CNT_W      = 17,
  parameter int unsigned STEP_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic                  enable,
  input  logic signed [CNT_W:0] err,
  output logic [TUNE_W-1:0]     tune
);

  localparam int unsigned ERR_W = CNT_W + 1;
  localparam int unsigned SUM_W = ((TUNE_W > ERR_W) ? TUNE_W : ERR_W) + 2;
  localparam logic signed [SUM_W-1:0] TOP_V =
    $signed({{(SUM_W-TUNE_W){1'b0}}, {TUNE_W{1'b1}}});
  localparam logic [TUNE_W-1:0] MID_V = {1'b1, {(TUNE_W-1){1'b0}}};

  logic signed [SUM_W-1:0] err_ext, step, sum;

  assign err_ext = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};
  assign step    = err_ext >>> STEP_SHIFT;
  assign sum     = $signed({{(SUM_W-TUNE_W){1'b0}}, tune}) + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune <= MID_V;
    end else if (upd && enable) begin
      if (sum < 0)          tune <= '0;
      else if (sum > TOP_V) tune <= {TUNE_W{1'b1}};
      else                  tune <= sum[TUNE_W-1:0];
    end
  end

  AST_TUNE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && enable) |=> $stable(tune)); // R6
  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && enable && err[ERR_W-1]) |=> (tune <= $past(tune))); // R7
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && enable && !err[ERR_W-1]) |=> (tune >= $past(tune))); // R7

endmodule

// File: rtl/ref_holdover_monitor.sv
module ref_holdover_monitor
  import ref_holdover_pkg::*;
#(
  parameter int unsigned WIN_LOG2   = 16,
  parameter int unsigned PRE_LOG2   = 5,
  parameter int unsigned TUNE_W     = 16,
  parameter int unsigned STEP_SHIFT = 2,
  parameter int unsigned TOL_PPM    = 300
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              ref_a,
  input  logic              ref_b,
  input  logic              ref_pick,
  input  logic [3:0]        ratio_code,
  output logic              ref_ok,
  output logic [TUNE_W-1:0] tune_code,
  output logic              bypass_on
);

  localparam int unsigned CNT_W  = WIN_LOG2 + 1;
  localparam int unsigned SHIFT  = WIN_LOG2 - PRE_LOG2;
  localparam int unsigned NCODES = 16;

  logic [3:0] code_q;
  logic       pick_q;
  logic       bypass_q;
  logic       restart;
  logic       enable;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= BYPASS_CODE;
      pick_q   <= 1'b1;
      bypass_q <= 1'b0;
    end else begin
      code_q   <= ratio_code;
      pick_q   <= ref_pick;
      bypass_q <= (ratio_code == BYPASS_CODE);
    end
  end

  assign restart   = (ratio_code != code_q) || (ref_pick != pick_q);
  assign enable    = ~bypass_q;
  assign bypass_on = bypass_q;

  // One prescaler per reference input
  logic [1:0] ref_in;
  logic [1:0] tap;
  assign ref_in = {ref_b, ref_a};

  for (genvar g = 0; g < 2; g++) begin : g_pre
    ref_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .ref_clk (ref_in[g]),
      .rst_n   (rst_n),
      .tap     (tap[g])
    );
  end

  logic sel_tap;
  assign sel_tap = ref_pick ? tap[0] : tap[1];

  // Expected count and tolerance for every code, fixed at elaboration
  logic [CNT_W-1:0] exp_tab [NCODES];
  logic [CNT_W-1:0] tol_tab [NCODES];

  for (genvar c = 0; c < NCODES; c++) begin : g_tab
    localparam longint unsigned EXP_C = expected_count(4'(c), SHIFT);
    localparam longint unsigned TOL_C = tol_count(EXP_C, TOL_PPM);
    assign exp_tab[c] = CNT_W'(EXP_C);
    assign tol_tab[c] = CNT_W'(TOL_C);
  end

  logic                  win_done;
  logic [CNT_W-1:0]      win_count;
  logic                  upd;
  logic signed [CNT_W:0] err_q;

  edge_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_win (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .tap_async (sel_tap),
    .restart   (restart),
    .enable    (enable),
    .win_done  (win_done),
    .win_count (win_count)
  );

  window_judge #(.CNT_W(CNT_W)) u_judge (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .enable    (enable),
    .win_done  (win_done),
    .win_count (win_count),
    .exp_cnt   (exp_tab[code_q]),
    .tol       (tol_tab[code_q]),
    .flag      (ref_ok),
    .upd       (upd),
    .err_q     (err_q)
  );

  tune_tracker #(.TUNE_W(TUNE_W), .CNT_W(CNT_W), .STEP_SHIFT(STEP_SHIFT)) u_tune (
    .clk    (osc_clk),
    .rst_n  (rst_n),
    .upd    (upd),
    .enable (enable),
    .err    (err_q),
    .tune   (tune_code)
  );

  AST_BYPASS_LOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ($past(bypass_on) && bypass_on) |-> !ref_ok); // R8
  AST_BYPASS_FREEZE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ($past(bypass_on) && bypass_on) |-> $stable(tune_code)); // R8

endmodule

// File: tb/ref_holdover_monitor_bench.sv
module ref_holdover_monitor_bench;

  localparam int CLK_PERIOD = 10000;
  localparam int W          = 1024;
  localparam int TW         = 4;
  localparam int MID        = 8;
  localparam int TMAX       = 15;

  logic          osc_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_a = 1'b0;
  logic          ref_b = 1'b0;
  logic          ref_pick = 1'b1;
  logic [3:0]    ratio_code = 4'b1001;
  logic          ref_ok;
  logic [TW-1:0] tune_code;
  logic          bypass_on;

  int a_half = 5000;
  int b_half = 5000;
  bit a_on = 0;
  bit b_on = 0;
  bit running = 0;
  int checks = 0;
  int errors = 0;

  ref_holdover_monitor #(
    .WIN_LOG2(10), .PRE_LOG2(5), .TUNE_W(TW), .STEP_SHIFT(0), .TOL_PPM(300)
  ) u_ref_holdover_monitor (
    .osc_clk    (osc_clk),
    .rst_n      (rst_n),
    .ref_a      (ref_a),
    .ref_b      (ref_b),
    .ref_pick   (ref_pick),
    .ratio_code (ratio_code),
    .ref_ok     (ref_ok),
    .tune_code  (tune_code),
    .bypass_on  (bypass_on)
  );

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

  initial forever begin
    if (a_on) begin ref_a = 1'b1; #(a_half); ref_a = 1'b0; #(a_half); end
    else begin ref_a = 1'b0; #(CLK_PERIOD); end
  end

  initial forever begin
    if (b_on) begin ref_b = 1'b1; #(b_half); ref_b = 1'b0; #(b_half); end
    else begin ref_b = 1'b0; #(CLK_PERIOD); end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  // Behavioural model: bypass state seen at each rising edge
  bit exp_byp = 0;
  always @(posedge osc_clk) begin
    if (!rst_n) exp_byp = 0;
    else        exp_byp = (ratio_code == 4'b0000);
  end

  // Per-clock comparison against the model
  bit byp_prev = 0;
  bit ok_prev = 0;
  int tune_prev = MID;
  always @(negedge osc_clk) begin
    if (running) begin
      chk(bypass_on == exp_byp, "R8 bypass_on per clock", int'(bypass_on), int'(exp_byp));
      if (byp_prev && exp_byp)
        chk(!ref_ok, "R8 ref_ok low in bypass", int'(ref_ok), 0);
      if (int'(tune_code) != tune_prev) begin
        chk(ok_prev && ref_ok && !exp_byp, "R6 tune moved without valid flag",
            int'(tune_code), tune_prev);
        chk((int'(tune_code) - tune_prev <= 1) && (tune_prev - int'(tune_code) <= 1),
            "R7 tune step size (no wrap)", int'(tune_code), tune_prev);
      end
    end
    byp_prev  = exp_byp;
    ok_prev   = ref_ok;
    tune_prev = int'(tune_code);
  end

  initial begin
    repeat (190000) @(posedge osc_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run incomplete, actual cycles=190000 expected fewer");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int held_tune;
  int lows;

  initial begin
    // R1: reset state
    wait_cyc(3);
    chk(ref_ok == 1'b0, "R1 reset ref_ok", int'(ref_ok), 0);
    chk(int'(tune_code) == MID, "R1 reset tune_code", int'(tune_code), MID);
    chk(bypass_on == 1'b0, "R1 reset bypass_on", int'(bypass_on), 0);
    a_on = 1;
    wait_cyc(2);
    rst_n = 1'b1;
    running = 1;

    // R5: a good reference needs two windows before the flag rises
    wait_cyc(W + W/2);
    chk(ref_ok == 1'b0, "R5 flag waits for second window", int'(ref_ok), 0);
    wait_cyc(2*W);
    chk(ref_ok == 1'b1, "R4 ratio 1 in range on ref_a", int'(ref_ok), 1);

    // R2: select the stopped ref_b; ref_a keeps running
    ref_pick = 1'b0;
    wait_cyc(W + W/2);
    chk(ref_ok == 1'b1, "R5 single bad window keeps flag", int'(ref_ok), 1);
    wait_cyc(W);
    chk(ref_ok == 1'b0, "R2 stopped ref_b selected drops flag", int'(ref_ok), 0);
    held_tune = int'(tune_code);
    wait_cyc(2*W);
    chk(int'(tune_code) == held_tune, "R6 tune held while failed", int'(tune_code), held_tune);
    b_on = 1;
    wait_cyc(3*W + W/2);
    chk(ref_ok == 1'b1, "R10 flag returns on ref_b", int'(ref_ok), 1);

    // R3: ratio table entries with a matching reference on ref_a
    ref_pick = 1'b1;
    b_on = 0;
    begin
      logic [3:0] codes [7] = '{4'b1000, 4'b1111, 4'b1100, 4'b1110, 4'b0011, 4'b0101, 4'b0001};
      int halves [7] = '{2500, 1250, 625, 833, 15000, 6250, 40000};
      for (int i = 0; i < 7; i++) begin
        a_half = halves[i];
        ratio_code = codes[i];
        wait_cyc(3*W + W/2);
        chk(ref_ok == 1'b1, $sformatf("R3 code %b matched reference", codes[i]),
            int'(ref_ok), 1);
      end
    end

    // R4: reference at ratio 1 while code asks for ratio 2
    a_half = 5000;
    ratio_code = 4'b1000;
    wait_cyc(3*W + W/2);
    chk(ref_ok == 1'b0, "R4 wrong ratio judged out of range", int'(ref_ok), 0);

    // R9/R5: restart aligns windows; a gap inside one window is tolerated
    ratio_code = 4'b1001;
    wait_cyc(3*W + W/4);
    chk(ref_ok == 1'b1, "R10 flag back after ratio fixed", int'(ref_ok), 1);
    lows = 0;
    a_on = 0;
    for (int i = 0; i < W/2; i++) begin
      @(negedge osc_clk);
      if (!ref_ok) lows++;
    end
    a_on = 1;
    for (int i = 0; i < 3*W; i++) begin
      @(negedge osc_clk);
      if (!ref_ok) lows++;
    end
    chk(lows == 0, "R9 R5 gap inside one restarted window ignored", lows, 0);

    // R8: bypass
    ratio_code = 4'b0000;
    wait_cyc(1);
    chk(bypass_on == 1'b1, "R8 bypass_on after one clock", int'(bypass_on), 1);
    held_tune = int'(tune_code);
    wait_cyc(2*W);
    chk(ref_ok == 1'b0, "R8 flag low in bypass", int'(ref_ok), 0);
    chk(int'(tune_code) == held_tune, "R8 tune frozen in bypass", int'(tune_code), held_tune);

    // R7: slow reference within tolerance pulls tune to the lower rail
    ratio_code = 4'b1001;
    a_half = 5150;
    wait_cyc(22*W);
    chk(bypass_on == 1'b0, "R8 bypass released", int'(bypass_on), 0);
    chk(ref_ok == 1'b1, "R4 3 percent slow still in range", int'(ref_ok), 1);
    chk(int'(tune_code) == 0, "R7 saturate at zero", int'(tune_code), 0);

    // R7: fast reference pulls tune to the upper rail
    a_half = 4854;
    wait_cyc(22*W);
    chk(ref_ok == 1'b1, "R4 3 percent fast still in range", int'(ref_ok), 1);
    chk(int'(tune_code) == TMAX, "R7 saturate at max", int'(tune_code), TMAX);

    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule